// File: doc/BRIEF.md
# T1 Bit-Oriented Message Transceiver

This block carries short priority codes over a 4 kb/s T1 facility data link. It handles both directions. The transmitter sends a 16-bit pattern over and over. Each pattern is a run of eight ones, then a byte of the form 0xxxxxx0. The six inner bits of that byte come from a code input. The receiver hunts for the same header in the incoming bit stream and captures the byte that follows it. A code is accepted only after it has persisted over recent slots. The accepted code is then held in an output register, and an optional one-cycle interrupt marks each new code.

Serial bits move one per enable strobe in each direction, so the block runs in the system clock domain at any link rate. The data-link multiplexer above the block decides when a bit slot occurs. A pre-empt input lets that layer borrow the link for message-oriented bursts. The transmitter first finishes the pattern it is sending, falls silent, and starts again from the head of the pattern when the pre-empt is released. The pacing of those bursts is left to the layer that drives the pre-empt: at most 100 ms, at most once per second.

Top module: `bom_xcvr`

## Requirements
- R1: While reset is applied and after its release, `tx_drive` is 0, `tx_bit` is 1, `rx_code` is 0, `rx_valid` is 0 and `irq` is 0.
- R2: While `tx_drive` is 1, `tx_bit` presents the pattern one bit per `tx_strobe`, in this order: eight 1s, a 0, `tx_code[5]` down to `tx_code[0]`, and a final 0. The bit advances only on a strobe.
- R3: The code is sampled when a pattern starts. A change to `tx_code` in the middle of a pattern first appears in the next pattern.
- R4: When `tx_en` is 0, `tx_drive` is 0 from the next cycle on and `tx_bit` rests at 1. If `tx_en` rises while the pre-empt is low, `tx_drive` goes to 1 one cycle later, and sending restarts at the first header bit.
- R5: When `tx_preempt` is asserted, the pattern in flight is completed. `tx_drive` falls after its 16th bit. When the pre-empt is released, sending resumes at the first header bit.
- R6: The receiver frames a slot as follows: eight 1s, a 0, six code bits (first bit received is the code MSB), and a closing bit. A closing bit of 1 marks the slot as invalid. Bits that come before a header are ignored.
- R7: A candidate code is copied to `rx_code` once at least 7 of the last 10 slots carried it validly. An invalid slot counts as a miss but does not discard the candidate. `rx_code` changes two clock cycles after the strobe that carries a slot's closing bit.
- R8: A valid slot with a code different from the candidate starts a new candidate, and the earlier history is discarded.
- R9: Each load of a new code raises `irq` for exactly one cycle when `irq_en` is 1. When `irq_en` is 0, the code still loads but `irq` stays 0.
- R10: When the persistent candidate equals the code already held, there is no reload and no `irq`. `rx_valid` becomes 1 at the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| tx_preempt | input | 1 | Release the link at the next pattern boundary |
| tx_code | input | 6 | Code placed inside the transmitted byte |
| tx_strobe | input | 1 | One transmit bit slot |
| tx_bit | output | 1 | Transmit data bit |
| tx_drive | output | 1 | Transmitter owns the link |
| rx_strobe | input | 1 | One receive bit slot |
| rx_bit | input | 1 | Receive data bit |
| irq_en | input | 1 | Interrupt enable |
| rx_code | output | 6 | Last validated received code |
| rx_valid | output | 1 | A code has been validated since reset |
| irq | output | 1 | One-cycle new-code pulse |

## Verification
Two events can land in the same clock cycle: the transmitter wrapping to a new pattern and reloading its code, and the receiver loading a newly validated code. The bench provokes this by looping the transmit output straight into the receiver on shared strobes. The loop runs through a code change, so the load of the new code falls next to a pattern wrap. It is judged by the held code, one `irq` pulse for the whole run, and unbroken transmit framing. A second collision is a pre-empt request raised partway through a pattern. The bench checks that every remaining bit of that pattern is still sent before the link is released.

// File: rtl/bom_pkg.sv
package bom_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_SEND = 1'b1} tx_state_e;
  typedef enum logic {RX_HUNT = 1'b0, RX_CAPT = 1'b1} rx_state_e;
endpackage

// File: rtl/bom_rst_sync.sv
module bom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/bom_tx.sv
module bom_tx
  import bom_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int HDR_ONES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_preempt,
  input  logic              tx_strobe,
  input  logic [CODE_W-1:0] tx_code,
  output logic              tx_bit,
  output logic              tx_drive
);
  localparam int PAT_LEN = HDR_ONES + CODE_W + 2;
  localparam int PH_W    = $clog2(PAT_LEN);
  localparam logic [PH_W-1:0] LAST_P = PH_W'(PAT_LEN - 1);

  tx_state_e         st_q, st_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [PAT_LEN-1:0] word;
  logic [PH_W-1:0]   bit_idx;
  logic              at_last;

  assign word    = {{HDR_ONES{1'b1}}, 1'b0, code_q, 1'b0};
  assign at_last = (phase_q == LAST_P);
  assign bit_idx = LAST_P - phase_q;

  always_comb begin
    st_d    = st_q;
    phase_d = phase_q;
    code_d  = code_q;
    case (st_q)
      TX_IDLE: begin
        if (tx_en && !tx_preempt) begin
          st_d    = TX_SEND;
          phase_d = '0;
          code_d  = tx_code;
        end
      end
      TX_SEND: begin
        if (!tx_en) begin
          st_d    = TX_IDLE;
          phase_d = '0;
        end else if (tx_strobe) begin
          if (at_last) begin
            phase_d = '0;
            if (tx_preempt) st_d   = TX_IDLE;
            else            code_d = tx_code;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      phase_q <= '0;
      code_q  <= '0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
      code_q  <= code_d;
    end
  end

  assign tx_drive = (st_q == TX_SEND);
  assign tx_bit   = tx_drive ? word[bit_idx] : 1'b1;

  AST_TX_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_drive) else $error("tx drives while disabled"); // R4
  AST_TX_RESTART_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_drive) |-> (phase_q == '0)) else $error("tx resumed mid pattern"); // R4
  AST_TX_HOLDS_TO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drive && tx_en && !(tx_strobe && at_last) |=> tx_drive) else $error("tx released early"); // R5
  AST_TX_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drive && tx_en && !tx_strobe |=> $stable(phase_q)) else $error("tx moved without strobe"); // R2
endmodule

// File: rtl/bom_rx_align.sv
module bom_rx_align
  import bom_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int HDR_ONES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic              rx_bit,
  output logic              slot_evt,
  output logic              slot_ok,
  output logic [CODE_W-1:0] slot_code
);
  localparam int HUNT_W = HDR_ONES + 1;
  localparam int CNT_W  = $clog2(CODE_W + 1);
  localparam logic [HUNT_W-1:0] HDR      = {{HDR_ONES{1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(CODE_W);

  rx_state_e         st_q, st_d;
  logic [HUNT_W-1:0] hunt_q, hunt_d, hunt_n;
  logic [CODE_W-1:0] cap_q, cap_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              evt_q, evt_d, ok_q, ok_d;
  logic [CODE_W-1:0] code_q, code_d;

  assign hunt_n = {hunt_q[HUNT_W-2:0], rx_bit};

  always_comb begin
    st_d   = st_q;
    hunt_d = hunt_q;
    cap_d  = cap_q;
    cnt_d  = cnt_q;
    evt_d  = 1'b0;
    ok_d   = ok_q;
    code_d = code_q;
    if (rx_strobe) begin
      case (st_q)
        RX_HUNT: begin
          hunt_d = hunt_n;
          if (hunt_n == HDR) begin
            st_d  = RX_CAPT;
            cnt_d = '0;
          end
        end
        RX_CAPT: begin
          if (cnt_q == CNT_LAST) begin
            evt_d  = 1'b1;
            ok_d   = !rx_bit;
            code_d = cap_q;
            st_d   = RX_HUNT;
            hunt_d = '0;
          end else begin
            cap_d = {cap_q[CODE_W-2:0], rx_bit};
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_HUNT;
      hunt_q <= '0;
      cap_q  <= '0;
      cnt_q  <= '0;
      evt_q  <= 1'b0;
      ok_q   <= 1'b0;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      hunt_q <= hunt_d;
      cap_q  <= cap_d;
      cnt_q  <= cnt_d;
      evt_q  <= evt_d;
      ok_q   <= ok_d;
      code_q <= code_d;
    end
  end

  assign slot_evt  = evt_q;
  assign slot_ok   = ok_q;
  assign slot_code = code_q;

  AST_SLOT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_evt |-> $past(rx_strobe)) else $error("slot without strobe"); // R6
  AST_SLOT_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_evt |=> !slot_evt) else $error("slot event repeated"); // R6
endmodule

// File: rtl/bom_rx_vote.sv
module bom_rx_vote #(
  parameter int CODE_W = 6,
  parameter int WIN    = 10,
  parameter int MIN    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_evt,
  input  logic              slot_ok,
  input  logic [CODE_W-1:0] slot_code,
  input  logic              irq_en,
  output logic [CODE_W-1:0] rx_code,
  output logic              rx_valid,
  output logic              irq
);
  localparam int ONES_W = $clog2(WIN + 1);
  localparam logic [ONES_W-1:0] MIN_P = ONES_W'(MIN);

  logic [WIN-1:0]    hist_q, hist_d;
  logic [CODE_W-1:0] cand_q, cand_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              valid_q, valid_d, irq_q, irq_d;
  logic [ONES_W-1:0] ones;
  logic              match, restart, load;

  assign match   = slot_ok && (slot_code == cand_q);
  assign restart = slot_ok && (slot_code != cand_q);

  always_comb begin
    hist_d = hist_q;
    cand_d = cand_q;
    if (slot_evt) begin
      if (restart) begin
        cand_d = slot_code;
        hist_d = WIN'(1);
      end else begin
        hist_d = {hist_q[WIN-2:0], match};
      end
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN; i++) ones = ones + ONES_W'(hist_d[i]);
  end

  assign load = slot_evt && (ones >= MIN_P) && (!valid_q || (cand_d != code_q));

  always_comb begin
    code_d  = code_q;
    valid_d = valid_q;
    irq_d   = load && irq_en;
    if (load) begin
      code_d  = cand_d;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      cand_q  <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      cand_q  <= cand_d;
      code_q  <= code_d;
      valid_q <= valid_d;
      irq_q   <= irq_d;
    end
  end

  assign rx_code  = code_q;
  assign rx_valid = valid_q;
  assign irq      = irq_q;

  AST_CODE_MOVES_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_code) |-> $past(slot_evt)) else $error("code changed off slot"); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_evt && slot_ok && (slot_code != cand_q) |=> ($countones(hist_q) == 1)) else $error("history kept"); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en)) else $error("irq while masked"); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("irq longer than one cycle"); // R9
endmodule

// File: rtl/bom_xcvr.sv
module bom_xcvr #(
  parameter int CODE_W   = 6,
  parameter int HDR_ONES = 8,
  parameter int WIN      = 10,
  parameter int MIN      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_preempt,
  input  logic [CODE_W-1:0] tx_code,
  input  logic              tx_strobe,
  output logic              tx_bit,
  output logic              tx_drive,
  input  logic              rx_strobe,
  input  logic              rx_bit,
  input  logic              irq_en,
  output logic [CODE_W-1:0] rx_code,
  output logic              rx_valid,
  output logic              irq
);
  logic              rst_n_s;
  logic              slot_evt, slot_ok;
  logic [CODE_W-1:0] slot_code;

  bom_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  bom_tx #(.CODE_W(CODE_W), .HDR_ONES(HDR_ONES)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .tx_en(tx_en), .tx_preempt(tx_preempt),
    .tx_strobe(tx_strobe), .tx_code(tx_code), .tx_bit(tx_bit), .tx_drive(tx_drive)
  );

  bom_rx_align #(.CODE_W(CODE_W), .HDR_ONES(HDR_ONES)) u_align (
    .clk(clk), .rst_n(rst_n_s), .rx_strobe(rx_strobe), .rx_bit(rx_bit),
    .slot_evt(slot_evt), .slot_ok(slot_ok), .slot_code(slot_code)
  );

  bom_rx_vote #(.CODE_W(CODE_W), .WIN(WIN), .MIN(MIN)) u_vote (
    .clk(clk), .rst_n(rst_n_s), .slot_evt(slot_evt), .slot_ok(slot_ok),
    .slot_code(slot_code), .irq_en(irq_en), .rx_code(rx_code),
    .rx_valid(rx_valid), .irq(irq)
  );
endmodule

// File: tb/bom_xcvr_bench.sv
`timescale 1ns/1ps
module bom_xcvr_bench;
  logic       clk = 1'b0;
  logic       rst_n, tx_en, tx_preempt, tx_strobe, rx_strobe, rx_bit, irq_en;
  logic [5:0] tx_code, rx_code;
  logic       tx_bit, tx_drive, rx_valid, irq;
  int         checks = 0, errors = 0, irq_cnt = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  bom_xcvr u_bom_xcvr (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_preempt(tx_preempt),
    .tx_code(tx_code), .tx_strobe(tx_strobe), .tx_bit(tx_bit), .tx_drive(tx_drive),
    .rx_strobe(rx_strobe), .rx_bit(rx_bit), .irq_en(irq_en),
    .rx_code(rx_code), .rx_valid(rx_valid), .irq(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  localparam logic [5:0] CA = 6'h15, CB = 6'h2A, CC = 6'h0F, Z = 6'h00;
  // {slot valid, slot code, expected rx_code, expected irq count}
  localparam logic [13:0] TBL [30] = '{
    {1'b1,CA,Z,1'b0}, {1'b1,CA,Z,1'b0}, {1'b1,CA,Z,1'b0}, {1'b1,CA,Z,1'b0},
    {1'b1,CA,Z,1'b0}, {1'b1,CA,Z,1'b0}, {1'b1,CA,CA,1'b1}, {1'b0,CA,CA,1'b0},
    {1'b1,CA,CA,1'b0}, {1'b1,CB,CA,1'b0}, {1'b1,CB,CA,1'b0}, {1'b1,CB,CA,1'b0},
    {1'b0,CB,CA,1'b0}, {1'b1,CB,CA,1'b0}, {1'b1,CB,CA,1'b0}, {1'b1,CB,CA,1'b0},
    {1'b1,CB,CB,1'b1}, {1'b1,CC,CB,1'b0}, {1'b1,CC,CB,1'b0}, {1'b1,CC,CB,1'b0},
    {1'b1,CC,CB,1'b0}, {1'b1,CC,CB,1'b0}, {1'b1,CC,CB,1'b0}, {1'b1,CB,CB,1'b0},
    {1'b1,CB,CB,1'b0}, {1'b1,CB,CB,1'b0}, {1'b1,CB,CB,1'b0}, {1'b1,CB,CB,1'b0},
    {1'b1,CB,CB,1'b0}, {1'b1,CB,CB,1'b0}
  };

  function automatic logic [15:0] pat(input logic [5:0] c);
    return {8'hFF, 1'b0, c, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rx_send_bit(input logic b);
    @(negedge clk); rx_strobe = 1'b1; rx_bit = b;
    @(negedge clk); rx_strobe = 1'b0;
  endtask

  task automatic rx_slot(input logic ok, input logic [5:0] c);
    logic [15:0] w;
    w = {8'hFF, 1'b0, c, ~ok};
    for (int i = 15; i >= 0; i--) rx_send_bit(w[i]);
    repeat (2) @(negedge clk);
  endtask

  // collects n transmit bits, optionally looping them into the receiver
  task automatic tx_bits(input int n, input logic loop, inout logic [15:0] w);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      w = {w[14:0], tx_bit};
      tx_strobe = 1'b1;
      if (loop) begin rx_strobe = 1'b1; rx_bit = tx_bit; end
      @(negedge clk);
      tx_strobe = 1'b0; rx_strobe = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    rst_n = 1'b0; tx_en = 1'b0; tx_preempt = 1'b0; tx_strobe = 1'b0; tx_code = '0;
    rx_strobe = 1'b0; rx_bit = 1'b0; irq_en = 1'b1; w = '0;
    repeat (4) @(negedge clk);
    check("R1 tx_drive in reset", 32'(tx_drive), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 tx_drive", 32'(tx_drive), 0);
    check("R1 tx_bit", 32'(tx_bit), 1);
    check("R1 rx_code", 32'(rx_code), 0);
    check("R1 rx_valid", 32'(rx_valid), 0);
    check("R1 irq", 32'(irq), 0);

    // R6 leading junk before the first header
    rx_send_bit(1'b0); rx_send_bit(1'b1); rx_send_bit(1'b1); rx_send_bit(1'b0);

    // vector table: R6 R7 R8 R9 R10
    for (int i = 0; i < 30; i++) begin
      irq_cnt = 0;
      rx_slot(TBL[i][13], TBL[i][12:7]);
      check($sformatf("R7 R8 R10 rx_code entry %0d", i), 32'(rx_code), 32'(TBL[i][6:1]));
      check($sformatf("R9 irq count entry %0d", i), irq_cnt, 32'(TBL[i][0]));
      check($sformatf("R10 rx_valid entry %0d", i), 32'(rx_valid), 32'(TBL[i][6:1] != 0));
    end

    // R9 masked interrupt: code still loads
    irq_en = 1'b0; irq_cnt = 0;
    for (int i = 0; i < 7; i++) rx_slot(1'b1, 6'h07);
    check("R9 masked load code", 32'(rx_code), 32'h07);
    check("R9 masked irq count", irq_cnt, 0);
    irq_en = 1'b1;

    // R4 enable and R2 pattern order
    @(negedge clk); tx_code = 6'h2D; tx_en = 1'b1;
    @(negedge clk);
    check("R4 drive after enable", 32'(tx_drive), 1);
    repeat (3) @(negedge clk);
    check("R2 no advance without strobe", 32'(tx_bit), 1);
    tx_bits(16, 1'b0, w);
    check("R2 pattern word", 32'(w), 32'(pat(6'h2D)));

    // R3 mid-pattern code change
    tx_bits(4, 1'b0, w);
    tx_code = 6'h12;
    tx_bits(12, 1'b0, w);
    check("R3 old code kept", 32'(w), 32'(pat(6'h2D)));
    tx_bits(16, 1'b0, w);
    check("R3 new code next", 32'(w), 32'(pat(6'h12)));

    // R5 pre-empt in the middle of a pattern
    tx_bits(5, 1'b0, w);
    tx_preempt = 1'b1;
    @(negedge clk);
    check("R5 still driving", 32'(tx_drive), 1);
    tx_bits(11, 1'b0, w);
    check("R5 pattern completed", 32'(w), 32'(pat(6'h12)));
    check("R5 released at boundary", 32'(tx_drive), 0);
    check("R5 idle mark", 32'(tx_bit), 1);
    repeat (4) @(negedge clk);
    check("R5 stays off", 32'(tx_drive), 0);
    tx_preempt = 1'b0;
    @(negedge clk);
    check("R5 resume drive", 32'(tx_drive), 1);
    tx_bits(16, 1'b0, w);
    check("R5 resume at head", 32'(w), 32'(pat(6'h12)));

    // R4 disable mid-pattern, restart at head
    tx_bits(3, 1'b0, w);
    tx_en = 1'b0;
    @(negedge clk);
    check("R4 drive off", 32'(tx_drive), 0);
    check("R4 idle mark", 32'(tx_bit), 1);
    tx_en = 1'b1;
    @(negedge clk);
    check("R4 drive back", 32'(tx_drive), 1);
    tx_bits(16, 1'b0, w);
    check("R4 restart at head", 32'(w), 32'(pat(6'h12)));

    // loopback: tx reload and rx load in the same run (R2 R7 R9)
    tx_code = 6'h33; irq_cnt = 0;
    for (int p = 0; p < 10; p++) tx_bits(16, 1'b1, w);
    repeat (3) @(negedge clk);
    check("R2 loopback last word", 32'(w), 32'(pat(6'h33)));
    check("R7 loopback code", 32'(rx_code), 32'h33);
    check("R9 loopback irq count", irq_cnt, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule